// File: doc/BRIEF.md
# Buffered-Module Control Word Sequencer

This block sets up the register chip on a buffered memory module by writing its 4-bit control words one at a time. After a start pulse it walks the chip-select pairs in ascending order and skips every pair whose even chip select is not marked present. For each pair it first loads an 8-bit target mask that selects both chip selects of the pair. It then issues that pair's control words through a send/clear handshake with the downstream memory controller.

Two modes are available. Full initialization sends every defined word from 0 to 15 and leaves out the two reserved words. Frequency change resends only the words that depend on frequency, and computes them with the target speed code in place of the current one. Each command packs the chip select, the word number and the word's data into fixed bit positions. A programmable gap counter must expire before each send. The configuration arrives as flat vectors: presence mask, rank flags, module count, module maximum, speed codes and per-module data nibbles. These inputs are expected to stay stable while the block is busy.

Top module: `rcw_sequencer`

## Requirements
- R1: After a start, chip-select indices 0, 2, 4 and 6 are considered in ascending order. An index receives commands only when its bit in `cs_present_i` is set. With no index present, `done_o` pulses and no send occurs.
- R2: Before the first send to index c, `target_mask_o` becomes 2'b11 shifted left by c. It holds that value during every send to that index. It reads 0 after reset.
- R3: Initialization mode (`freq_mode_i`=0 at start) sends words 0,1,2,3,4,5,8,9,10,11,12,13,14,15 in that order to each present index. Words 6 and 7 are never sent.
- R4: Command layout: bits 22:20 hold the chip-select index and bit 18 is set when the word number is 8 or more. Bits 17:16 hold data[3:2], bits 4:3 hold data[1:0] and bits 2:0 hold word[2:0]. All other bits are 0.
- R5: Word 0 carries data 0x2 and word 9 carries data 0xD. Word 1 carries 0xC when the module is marked neither dual-rank nor quad-rank, and 0x0 otherwise. In initialization mode, words 10 to 15 carry 0x0.
- R6: The module index d is the chip-select index plus 1 when `alt_channel_i` is set. Words 3, 4 and 5 carry bits 4d+3:4d of `cw3_cfg_i`, `cw4_cfg_i` and `cw5_cfg_i`, and rank and mirror flags are read at bit d.
- R7: Word 2 data bit 2 is set in three cases. With max modules 4 and speed code 4, it is set when the module is not mirrored and either (quad-rank with count 1) or count 2. With max 4 and any other speed, it is set when the module is mirrored. With any other max, it is set when count > 1. Word 8 data bit 2 is set only with max 4, speed 4 and a mirrored module. All other data bits of words 2 and 8 are 0.
- R8: `send_o` rises with a new command and stays high, with `cmd_o` unchanged, until a cycle in which `send_ack_i` is high. In the next cycle `send_o` is low.
- R9: Before each send, `send_o` stays low for at least `gap_cycles_i`+1 cycles. Between two sends to the same index the gap is exactly `gap_cycles_i`+1 cycles.
- R10: Frequency-change mode (`freq_mode_i`=1 at start) sends, per present index, word 10, then word 2, then word 8. Word 10 carries data 1, 2 or 3 for `target_speed_i` 5, 6 or 7. Words 2 and 8 follow R7 with `target_speed_i` used as the speed code.
- R11: In frequency-change mode, a `target_speed_i` other than 5, 6 or 7 leaves out word 10 and still sends words 2 and 8.
- R12: After the last acknowledged send of a run, `done_o` is high for exactly one cycle and `busy_o` then falls. A start pulse while `busy_o` is high has no effect on the command stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, accepted only when idle |
| freq_mode_i | input | 1 | 0 selects initialization, 1 selects frequency change |
| cs_present_i | input | NUM_CS | Chip-select present mask |
| alt_channel_i | input | 1 | Only the second channel is populated (module index +1) |
| dual_rank_i | input | NUM_CS | Per-module dual-rank flags |
| quad_rank_i | input | NUM_CS | Per-module quad-rank flags |
| mirror_i | input | NUM_CS | Per-module mirrored/registered flags |
| dimm_count_i | input | CNT_W | Number of modules present |
| max_dimms_i | input | CNT_W | Maximum modules supported |
| speed_i | input | SPD_W | Current speed code |
| target_speed_i | input | SPD_W | Target speed code for frequency change |
| cw3_cfg_i | input | 4*NUM_CS | Word 3 data nibbles, one per module |
| cw4_cfg_i | input | 4*NUM_CS | Word 4 data nibbles, one per module |
| cw5_cfg_i | input | 4*NUM_CS | Word 5 data nibbles, one per module |
| gap_cycles_i | input | WAIT_W | Wait cycles before each send |
| send_ack_i | input | 1 | Downstream clears the send bit |
| cmd_o | output | 24 | Packed command |
| send_o | output | 1 | Send bit, held until cleared |
| target_mask_o | output | NUM_CS | Chip-select target mask |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle end-of-run pulse |

## Verification
The bench builds the block with NUM_CS=8 and WAIT_W=8. Eight chip selects make all four pairs reachable, which brings in the final-pair exit and, with the channel offset, module index 7 at the top of the 32-bit data vectors. The narrow gap counter keeps runs short. Gaps of 0 and 3 cover both the immediate-expiry path and the counted path of the wait. The stimulus varies the acknowledge latency, supplies target speeds both inside and outside the 5 to 7 set, and pulses a competing start during a run.

// File: rtl/rcw_pkg.sv
package rcw_pkg;
   localparam int CMD_W    = 24;
   localparam int WORD_W   = 4;
   localparam int DATA_W   = 4;
   localparam int CS_W     = 3;
   localparam int FIELD_W  = 4;
   localparam int CS_LSB   = 20;
   localparam int HI_BIT   = 18;
   localparam int DHI_LSB  = 16;
   localparam int DLO_LSB  = 3;

   typedef enum logic [2:0] {
      ST_IDLE, ST_SCAN, ST_WAIT, ST_SEND, ST_DONE
   } seq_state_e;

   localparam logic [WORD_W-1:0] WD_FIRST_INIT = 4'd0;
   localparam logic [WORD_W-1:0] WD_LAST_INIT  = 4'd15;
   localparam logic [WORD_W-1:0] WD_RSV_PRE    = 4'd5;
   localparam logic [WORD_W-1:0] WD_RSV_POST   = 4'd8;
   localparam logic [WORD_W-1:0] WD_FREQ       = 4'd10;
   localparam logic [WORD_W-1:0] WD_TERM       = 4'd2;
   localparam logic [WORD_W-1:0] WD_MIRR       = 4'd8;
endpackage

// File: rtl/rcw_word_data.sv
module rcw_word_data
   import rcw_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int CNT_W  = 4,
   parameter int SPD_W  = 4,
   localparam int DIMM_W = $clog2(NUM_CS),
   localparam int VEC_W  = NUM_CS * FIELD_W
) (
   input  logic [WORD_W-1:0] word_i,
   input  logic [DIMM_W-1:0] dimm_i,
   input  logic              freq_mode_i,
   input  logic [SPD_W-1:0]  speed_i,
   input  logic [SPD_W-1:0]  target_speed_i,
   input  logic [CNT_W-1:0]  max_dimms_i,
   input  logic [CNT_W-1:0]  dimm_count_i,
   input  logic [NUM_CS-1:0] dual_rank_i,
   input  logic [NUM_CS-1:0] quad_rank_i,
   input  logic [NUM_CS-1:0] mirror_i,
   input  logic [VEC_W-1:0]  cw3_cfg_i,
   input  logic [VEC_W-1:0]  cw4_cfg_i,
   input  logic [VEC_W-1:0]  cw5_cfg_i,
   output logic [DATA_W-1:0] data_o
);
   logic [DIMM_W+1:0] fbase;
   logic              eff_spd4;
   logic              max4;
   logic              mir;
   logic              multi_rank;
   logic              term_bit;
   logic              mirr_bit;
   logic [SPD_W-1:0]  eff_speed;
   logic [DATA_W-1:0] freq_data;

   assign fbase      = {dimm_i, 2'b00};
   assign eff_speed  = freq_mode_i ? target_speed_i : speed_i;
   assign eff_spd4   = (eff_speed == SPD_W'(4));
   assign max4       = (max_dimms_i == CNT_W'(4));
   assign mir        = mirror_i[dimm_i];
   assign multi_rank = dual_rank_i[dimm_i] | quad_rank_i[dimm_i];

   always_comb begin
      if (max4) begin
         if (eff_spd4)
            term_bit = ~mir & ((quad_rank_i[dimm_i] & (dimm_count_i == CNT_W'(1)))
                               | (dimm_count_i == CNT_W'(2)));
         else
            term_bit = mir;
      end else begin
         term_bit = (dimm_count_i > CNT_W'(1));
      end
   end

   assign mirr_bit = max4 & eff_spd4 & mir;

   always_comb begin
      case (target_speed_i)
         SPD_W'(5): freq_data = 4'h1;
         SPD_W'(6): freq_data = 4'h2;
         SPD_W'(7): freq_data = 4'h3;
         default:   freq_data = 4'h0;
      endcase
   end

   always_comb begin
      case (word_i)
         4'd0:    data_o = 4'h2;
         4'd1:    data_o = multi_rank ? 4'h0 : 4'hC;
         4'd2:    data_o = {1'b0, term_bit, 2'b00};
         4'd3:    data_o = cw3_cfg_i[fbase +: FIELD_W];
         4'd4:    data_o = cw4_cfg_i[fbase +: FIELD_W];
         4'd5:    data_o = cw5_cfg_i[fbase +: FIELD_W];
         4'd8:    data_o = {1'b0, mirr_bit, 2'b00};
         4'd9:    data_o = 4'hD;
         4'd10:   data_o = freq_mode_i ? freq_data : 4'h0;
         default: data_o = 4'h0;
      endcase
   end
endmodule

// File: rtl/rcw_cmd_pack.sv
module rcw_cmd_pack
   import rcw_pkg::*;
(
   input  logic [CS_W-1:0]   cs_i,
   input  logic [WORD_W-1:0] word_i,
   input  logic [DATA_W-1:0] data_i,
   output logic [CMD_W-1:0]  cmd_o
);
   always_comb begin
      cmd_o                         = '0;
      cmd_o[CS_LSB +: CS_W]         = cs_i;
      cmd_o[HI_BIT]                 = word_i[3];
      cmd_o[DHI_LSB +: 2]           = data_i[3:2];
      cmd_o[DLO_LSB +: 2]           = data_i[1:0];
      cmd_o[2:0]                    = word_i[2:0];
   end
endmodule

// File: rtl/rcw_gap_timer.sv
module rcw_gap_timer #(
   parameter int WAIT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_i,
   input  logic [WAIT_W-1:0] load_val_i,
   output logic              expired_o
);
   logic [WAIT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load_i)
         cnt_q <= load_val_i;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - WAIT_W'(1);
   end

   assign expired_o = (cnt_q == '0);

   AST_GAP_COUNTS_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - WAIT_W'(1))); // R9
endmodule

// File: rtl/rcw_sequencer.sv
module rcw_sequencer
   import rcw_pkg::*;
#(
   parameter int NUM_CS = 8,
   parameter int WAIT_W = 16,
   parameter int CNT_W  = 4,
   parameter int SPD_W  = 4,
   localparam int NUM_PAIRS = NUM_CS / 2,
   localparam int PIDX_W    = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1,
   localparam int DIMM_W    = $clog2(NUM_CS),
   localparam int VEC_W     = NUM_CS * FIELD_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic              freq_mode_i,
   input  logic [NUM_CS-1:0] cs_present_i,
   input  logic              alt_channel_i,
   input  logic [NUM_CS-1:0] dual_rank_i,
   input  logic [NUM_CS-1:0] quad_rank_i,
   input  logic [NUM_CS-1:0] mirror_i,
   input  logic [CNT_W-1:0]  dimm_count_i,
   input  logic [CNT_W-1:0]  max_dimms_i,
   input  logic [SPD_W-1:0]  speed_i,
   input  logic [SPD_W-1:0]  target_speed_i,
   input  logic [VEC_W-1:0]  cw3_cfg_i,
   input  logic [VEC_W-1:0]  cw4_cfg_i,
   input  logic [VEC_W-1:0]  cw5_cfg_i,
   input  logic [WAIT_W-1:0] gap_cycles_i,
   input  logic              send_ack_i,
   output logic [CMD_W-1:0]  cmd_o,
   output logic              send_o,
   output logic [NUM_CS-1:0] target_mask_o,
   output logic              busy_o,
   output logic              done_o
);
   // elaboration checks
   if (NUM_CS != 4 && NUM_CS != 8) begin : g_bad_num_cs
      initial $fatal(1, "NUM_CS must be 4 or 8");
   end
   if (WAIT_W < 1 || CNT_W < 3 || SPD_W < 3) begin : g_bad_width
      initial $fatal(1, "WAIT_W, CNT_W or SPD_W too narrow");
   end

   seq_state_e          state_q;
   logic                mode_q;
   logic [PIDX_W-1:0]   pair_q;
   logic [WORD_W-1:0]   word_q;
   logic [NUM_CS-1:0]   mask_q;
   logic [CMD_W-1:0]    cmd_q;
   logic [NUM_PAIRS-1:0] pair_pop;
   logic [NUM_CS-1:0]   pair_mask [NUM_PAIRS];
   logic [CS_W-1:0]     cs_idx;
   logic [DIMM_W-1:0]   dimm_idx;
   logic [DATA_W-1:0]   word_data;
   logic [CMD_W-1:0]    packed_cmd;
   logic                gap_done;
   logic                gap_load;
   logic                tgt_valid;
   logic                pair_last;
   logic                word_last;
   logic [WORD_W-1:0]   word_first;
   logic [WORD_W-1:0]   word_next;

   // per-pair presence and mask
   for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
      assign pair_pop[p]  = cs_present_i[2*p];
      assign pair_mask[p] = NUM_CS'(2'b11) << (2*p);
   end

   assign cs_idx    = CS_W'({pair_q, 1'b0});
   assign dimm_idx  = DIMM_W'({pair_q, 1'b0}) + DIMM_W'(alt_channel_i);
   assign pair_last = (pair_q == PIDX_W'(NUM_PAIRS - 1));
   assign tgt_valid = (target_speed_i == SPD_W'(5)) || (target_speed_i == SPD_W'(6))
                      || (target_speed_i == SPD_W'(7));

   // word ordering per mode
   always_comb begin
      if (mode_q) begin
         word_first = tgt_valid ? WD_FREQ : WD_TERM;
         word_last  = (word_q == WD_MIRR);
         word_next  = (word_q == WD_FREQ) ? WD_TERM : WD_MIRR;
      end else begin
         word_first = WD_FIRST_INIT;
         word_last  = (word_q == WD_LAST_INIT);
         word_next  = (word_q == WD_RSV_PRE) ? WD_RSV_POST : word_q + WORD_W'(1);
      end
   end

   rcw_word_data #(
      .NUM_CS (NUM_CS),
      .CNT_W  (CNT_W),
      .SPD_W  (SPD_W)
   ) u_data (
      .word_i         (word_q),
      .dimm_i         (dimm_idx),
      .freq_mode_i    (mode_q),
      .speed_i        (speed_i),
      .target_speed_i (target_speed_i),
      .max_dimms_i    (max_dimms_i),
      .dimm_count_i   (dimm_count_i),
      .dual_rank_i    (dual_rank_i),
      .quad_rank_i    (quad_rank_i),
      .mirror_i       (mirror_i),
      .cw3_cfg_i      (cw3_cfg_i),
      .cw4_cfg_i      (cw4_cfg_i),
      .cw5_cfg_i      (cw5_cfg_i),
      .data_o         (word_data)
   );

   rcw_cmd_pack u_pack (
      .cs_i   (cs_idx),
      .word_i (word_q),
      .data_i (word_data),
      .cmd_o  (packed_cmd)
   );

   assign gap_load = ((state_q == ST_SCAN) && pair_pop[pair_q])
                     || ((state_q == ST_SEND) && send_ack_i && !word_last);

   rcw_gap_timer #(.WAIT_W(WAIT_W)) u_gap (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (gap_load),
      .load_val_i (gap_cycles_i),
      .expired_o  (gap_done)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         mode_q  <= 1'b0;
         pair_q  <= '0;
         word_q  <= '0;
         mask_q  <= '0;
         cmd_q   <= '0;
      end else begin
         case (state_q)
            ST_IDLE: begin
               if (start_i) begin
                  mode_q  <= freq_mode_i;
                  pair_q  <= '0;
                  state_q <= ST_SCAN;
               end
            end
            ST_SCAN: begin
               if (pair_pop[pair_q]) begin
                  mask_q  <= pair_mask[pair_q];
                  word_q  <= word_first;
                  state_q <= ST_WAIT;
               end else if (pair_last) begin
                  state_q <= ST_DONE;
               end else begin
                  pair_q  <= pair_q + PIDX_W'(1);
               end
            end
            ST_WAIT: begin
               if (gap_done) begin
                  cmd_q   <= packed_cmd;
                  state_q <= ST_SEND;
               end
            end
            ST_SEND: begin
               if (send_ack_i) begin
                  if (!word_last) begin
                     word_q  <= word_next;
                     state_q <= ST_WAIT;
                  end else if (pair_last) begin
                     state_q <= ST_DONE;
                  end else begin
                     pair_q  <= pair_q + PIDX_W'(1);
                     state_q <= ST_SCAN;
                  end
               end
            end
            ST_DONE: state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign cmd_o         = cmd_q;
   assign send_o        = (state_q == ST_SEND);
   assign done_o        = (state_q == ST_DONE);
   assign busy_o        = (state_q != ST_IDLE);
   assign target_mask_o = mask_q;

   AST_SEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (send_o && !send_ack_i) |=> (send_o && $stable(cmd_o))); // R8
   AST_SEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (send_o && send_ack_i) |=> !send_o); // R8
   AST_MASK_IS_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      send_o |-> ($countones(target_mask_o) == 2)); // R2
   AST_NO_RESERVED: assert property (@(posedge clk) disable iff (!rst_n)
      send_o |-> !(!cmd_o[HI_BIT] && cmd_o[2:1] == 2'b11)); // R3
   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && !busy_o)); // R12
   AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> (!send_o && !done_o)); // R12
   AST_CS_FIELD_EVEN: assert property (@(posedge clk) disable iff (!rst_n)
      send_o |-> !cmd_o[CS_LSB]); // R1
endmodule

// File: tb/rcw_sequencer_tb.sv
module rcw_sequencer_tb;
   localparam int NUM_CS = 8;
   localparam int WAIT_W = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        fmode = 1'b0;
   logic [7:0]  present = '0;
   logic        alt = 1'b0;
   logic [7:0]  dr = '0, qr = '0, mir = '0;
   logic [3:0]  cnt = '0, maxd = '0, spd = '0, tspd = '0;
   logic [31:0] v3 = '0, v4 = '0, v5 = '0;
   logic [7:0]  gap = '0;
   logic        ack = 1'b0;
   logic [23:0] cmd;
   logic        send, busy, done;
   logic [7:0]  mask;

   int n_chk = 0, n_fail = 0;
   int q_cmd[$], q_mask[$], q_first[$];
   int lowrun = 0, done_seen = 0, ack_lat = 0, ack_dly = 0, cycles = 0;
   logic prev_send = 1'b0, prev_ack = 1'b0, mon_en = 1'b0;

   always #5 clk = ~clk;

   rcw_sequencer #(.NUM_CS(NUM_CS), .WAIT_W(WAIT_W)) u_dut (
      .clk(clk), .rst_n(rst_n), .start_i(start), .freq_mode_i(fmode),
      .cs_present_i(present), .alt_channel_i(alt), .dual_rank_i(dr),
      .quad_rank_i(qr), .mirror_i(mir), .dimm_count_i(cnt), .max_dimms_i(maxd),
      .speed_i(spd), .target_speed_i(tspd), .cw3_cfg_i(v3), .cw4_cfg_i(v4),
      .cw5_cfg_i(v5), .gap_cycles_i(gap), .send_ack_i(ack), .cmd_o(cmd),
      .send_o(send), .target_mask_o(mask), .busy_o(busy), .done_o(done));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ref_data(input int cs, input int w);
      int d, s, b;
      d = cs + int'(alt);
      s = fmode ? int'(tspd) : int'(spd);
      case (w)
         0: return 2;
         1: return (dr[d] || qr[d]) ? 0 : 12;
         2: begin
            if (maxd == 4 && s == 4) b = (!mir[d] && ((qr[d] && cnt == 1) || cnt == 2)) ? 1 : 0;
            else if (maxd == 4) b = mir[d] ? 1 : 0;
            else b = (cnt > 1) ? 1 : 0;
            return b * 4;
         end
         3: return int'((v3 >> (4 * d)) & 32'hF);
         4: return int'((v4 >> (4 * d)) & 32'hF);
         5: return int'((v5 >> (4 * d)) & 32'hF);
         8: return (maxd == 4 && s == 4 && mir[d]) ? 4 : 0;
         9: return 13;
         10: begin
            if (!fmode) return 0;
            if (tspd >= 5 && tspd <= 7) return int'(tspd) - 4;
            return 0;
         end
         default: return 0;
      endcase
   endfunction

   task automatic push(input int cs, input int w, inout int first);
      int dat;
      dat = ref_data(cs, w);
      q_cmd.push_back((cs << 20) | ((w >= 8 ? 1 : 0) << 18) | (((dat >> 2) & 3) << 16)
                      | ((dat & 3) << 3) | (w & 7));
      q_mask.push_back(3 << cs);
      q_first.push_back(first);
      first = 0;
   endtask

   // reference stream: behavioural walk over pairs and words
   task automatic build_ref();
      q_cmd.delete(); q_mask.delete(); q_first.delete();
      for (int cs = 0; cs < 8; cs += 2) begin
         int first;
         first = 1;
         if (present[cs]) begin
            if (!fmode) begin
               for (int w = 0; w < 16; w++)
                  if (w != 6 && w != 7) push(cs, w, first);
            end else begin
               if (tspd >= 5 && tspd <= 7) push(cs, 10, first);
               push(cs, 2, first);
               push(cs, 8, first);
            end
         end
      end
   endtask

   // acknowledge driver
   always @(negedge clk) begin
      if (ack) ack = 1'b0;
      else if (send) begin
         if (ack_dly >= ack_lat) begin ack = 1'b1; ack_dly = 0; end
         else ack_dly++;
      end
   end

   // per-clock comparison against the reference stream
   always @(negedge clk) begin
      if (mon_en) begin
         if (done) done_seen++;
         if (prev_send && !prev_ack)
            chk(send, "R8 send held until cleared", int'(send), 1);
         if (send && !prev_send) begin
            if (q_cmd.size() == 0) begin
               chk(1'b0, "R1 R3 R10 R11 unexpected send", int'(cmd), 0);
            end else begin
               int ec, em, ef;
               ec = q_cmd.pop_front(); em = q_mask.pop_front(); ef = q_first.pop_front();
               chk(int'(cmd) == ec, "R1 R3 R4 R5 R6 R7 R10 R11 command", int'(cmd), ec);
               chk(int'(mask) == em, "R2 target mask", int'(mask), em);
               if (ef != 0) chk(lowrun >= int'(gap) + 1, "R9 gap before first word", lowrun, int'(gap) + 1);
               else chk(lowrun == int'(gap) + 1, "R9 gap between words", lowrun, int'(gap) + 1);
            end
            lowrun = 0;
         end else if (!send) begin
            lowrun++;
         end
      end
      prev_send = send;
      prev_ack = ack;
   end

   // watchdog
   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000) begin
         chk(1'b0, "R12 watchdog expired", cycles, 150000);
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   task automatic run(input string tag, input bit mid_start);
      build_ref();
      done_seen = 0;
      lowrun = 0;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      for (int i = 0; i < 3000; i++) begin
         @(negedge clk);
         if (mid_start) begin
            start = (i == 20);
            if (i == 20) fmode = ~fmode;
            if (i == 21) fmode = ~fmode;
         end
         if (done_seen != 0) break;
      end
      start = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(q_cmd.size() == 0, {"R12 all words sent: ", tag}, q_cmd.size(), 0);
      chk(done_seen == 1, {"R12 single done pulse: ", tag}, done_seen, 1);
      chk(!busy, {"R12 idle after done: ", tag}, int'(busy), 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!send && !done && !busy, "R12 reset outputs idle", int'({send, done, busy}), 0);
      chk(mask == 8'h00, "R2 mask zero after reset", int'(mask), 0);
      chk(cmd == 24'h0, "R4 command zero after reset", int'(cmd), 0);
      rst_n = 1'b1;
      mon_en = 1'b1;
      @(negedge clk);

      // all pairs, initialization, max 4 at speed 4 with two modules
      fmode = 0; present = 8'h55; alt = 0; dr = 8'h02; qr = 8'h10; mir = 8'h04;
      cnt = 2; maxd = 4; spd = 4; tspd = 6;
      v3 = 32'h87654321; v4 = 32'hFEDCBA98; v5 = 32'h13579BDF; gap = 3; ack_lat = 1;
      run("init all pairs", 1'b0);

      // second channel only, other maximum, zero gap, competing start mid-run
      present = 8'h14; alt = 1; dr = 8'h08; qr = 8'h00; mir = 8'h20;
      cnt = 1; maxd = 2; spd = 3; gap = 0; ack_lat = 0;
      run("init alt channel with ignored start", 1'b1);

      // max 4, other speed: mirrored module sets the word 2 bit
      present = 8'h41; alt = 0; dr = 8'h00; qr = 8'h01; mir = 8'h40;
      cnt = 1; maxd = 4; spd = 5; gap = 2; ack_lat = 3;
      run("init mirrored pair", 1'b0);

      // frequency change to code 6, current speed deliberately different
      fmode = 1; present = 8'h05; qr = 8'h01; mir = 8'h04; cnt = 1; maxd = 4;
      spd = 4; tspd = 6; gap = 3; ack_lat = 2;
      run("freq change code 6", 1'b0);

      // frequency change with codes 5 and 7
      present = 8'hFF; alt = 1; mir = 8'h80; tspd = 5; gap = 1;
      run("freq change code 5", 1'b0);
      tspd = 7;
      run("freq change code 7", 1'b0);

      // invalid target code: word 10 left out, speed 4 enables word 8
      present = 8'h44; alt = 0; mir = 8'h44; cnt = 2; tspd = 4; spd = 6;
      run("freq change invalid code", 1'b0);

      // nothing present: immediate done
      fmode = 0; present = 8'hAA;
      run("no present pair", 1'b0);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule